// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a 16-bit digital-to-analog converter attached to an 8-bit processor bus. A host builds a 16-bit word in a pair of byte-wide input latches. It can write the low and high bytes separately, or it can stream the word in one bit at a time, most significant bit first, on bit 0 of the data bus. A separate transfer strobe then copies the whole word at once into an output register that drives the converter code. Because of this double buffering, the analog output never shows a half-updated word.

All bus controls are active low: chip select, write strobe, three register enables and clear. The write strobe is asynchronous to the system clock. It passes through a two-flop synchronizer, and each register update happens once, on the synchronized rising edge of the strobe. The update uses the chip select, enables and data sampled while the strobe was low. Clear returns both stages to the two's-complement bipolar-zero code. A mode input selects straight-binary (unipolar) coding by inverting the MSB on the way out, and it leaves the stored contents unchanged.

Top module: `dac_input_frontend`

## Requirements
- R1: After reset, with the mode input low, `code_out` is 0000h.
- R2: A write strobe or clear given while `cs_n` is high changes neither the input word nor the output register.
- R3: A write with only `lo_sel_n` low (of `lo_sel_n` and `hi_sel_n`) stores `data_in` into input bits 7:0 and leaves bits 15:8 unchanged.
- R4: A write with only `hi_sel_n` low (of `lo_sel_n` and `hi_sel_n`) stores `data_in` into input bits 15:8 and leaves bits 7:0 unchanged.
- R5: Writes to the input bytes do not change `code_out`. A write with `xfer_n` low copies the full 16-bit input word into the output register.
- R6: A write with both `lo_sel_n` and `hi_sel_n` low shifts the input word left by one and places `data_in[0]` in bit 0; bits 7:1 of `data_in` are ignored. Sixteen such writes therefore load a word sent MSB first.
- R7: When `xfer_n` is low in the same write as a byte enable, both actions take place. The output register receives the input word as it stood before that write.
- R8: Clear (`clr_n` low together with `cs_n` low) sets both input bytes and the output register to zero.
- R9: With `unipolar` high, `code_out` equals the output register with bit 15 inverted, so a cleared block shows 8000h. The stored contents are not changed by the mode input.
- R10: No register changes while the write strobe is still low. The update appears only after the strobe returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low, gates every register change |
| wr_n | input | 1 | Write strobe, active low, asynchronous; action on its rising edge |
| lo_sel_n | input | 1 | Low-byte enable, active low |
| hi_sel_n | input | 1 | High-byte enable, active low; with `lo_sel_n` low selects serial shift |
| xfer_n | input | 1 | Output-register transfer enable, active low |
| clr_n | input | 1 | Clear, active low, level sensitive |
| data_in | input | 8 | Byte data bus; bit 0 is the serial input in shift mode |
| unipolar | input | 1 | High selects straight-binary output coding (MSB inverted) |
| code_out | output | 16 | Converter code |

## Verification
The bench uses the default parameter values: an 8-bit bus, a 16-bit word and two synchronizer stages. With these values a full serial load takes sixteen strobes, so a complete MSB-first frame runs in a short simulation. The two-stage latency is short enough that checks made while the strobe is held low can show that nothing updates before the strobe is released. The pattern table is built so that each byte is overwritten by an ignored or later write before a transfer makes it visible. This means every no-effect and pre-write-value case shows up at `code_out`.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  typedef enum logic [1:0] {
    IN_HOLD  = 2'd0,
    IN_LOW   = 2'd1,
    IN_HIGH  = 2'd2,
    IN_SHIFT = 2'd3
  } in_op_e;

  function automatic in_op_e decode_in_op(input logic lo_n, input logic hi_n);
    case ({lo_n, hi_n})
      2'b00:   return IN_SHIFT;
      2'b01:   return IN_LOW;
      2'b10:   return IN_HIGH;
      default: return IN_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dacfe_strobe.sv
module dacfe_strobe
  import dacfe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              cs_n,
  input  logic              lo_sel_n,
  input  logic              hi_sel_n,
  input  logic              xfer_n,
  input  logic [BYTE_W-1:0] data_in,
  output logic              fire,
  output in_op_e            op,
  output logic              xfer,
  output logic [BYTE_W-1:0] data
);
  localparam int CAP_W = BYTE_W + 4;

  logic             wr_s;
  logic             wr_prev_q;
  logic             cap_en;
  logic [CAP_W-1:0] cap_q;
  logic [CAP_W-1:0] cap_d;
  logic             rise;

  dacfe_sync #(.STAGES(STAGES), .RST_VAL(1'b1)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .d(wr_n), .q(wr_s)
  );

  always_comb begin
    cap_en = ~wr_s;
    cap_d  = {cs_n, lo_sel_n, hi_sel_n, xfer_n, data_in};
    rise   = wr_s & ~wr_prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev_q <= 1'b1;
    else        wr_prev_q <= wr_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= {CAP_W{1'b1}};
    else if (cap_en) cap_q <= cap_d;
  end

  assign fire = rise & ~cap_q[CAP_W-1];
  assign op   = decode_in_op(cap_q[CAP_W-2], cap_q[CAP_W-3]);
  assign xfer = ~cap_q[CAP_W-4];
  assign data = cap_q[BYTE_W-1:0];

  p_single_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  p_fire_after_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(!wr_s));
endmodule

// File: rtl/dacfe_input_pair.sv
module dacfe_input_pair
  import dacfe_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                fire,
  input  in_op_e              op,
  input  logic [BYTE_W-1:0]   data,
  output logic [2*BYTE_W-1:0] word
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic              word_en;

  always_comb begin
    word_d  = word_q;
    word_en = clr | (fire & (op != IN_HOLD));
    if (clr) begin
      word_d = '0;
    end else begin
      case (op)
        IN_LOW:   word_d[BYTE_W-1:0]      = data;
        IN_HIGH:  word_d[WORD_W-1:BYTE_W] = data;
        IN_SHIFT: word_d = {word_q[WORD_W-2:0], data[0]};
        default:  word_d = word_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word = word_q;

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clr) |=> $stable(word_q));
  p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clr && op == IN_SHIFT) |=> word_q == {$past(word_q[WORD_W-2:0]), $past(data[0])});
  p_clear_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> word_q == '0);
endmodule

// File: rtl/dacfe_out_reg.sv
module dacfe_out_reg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              unipolar,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] code_out
);
  logic [WORD_W-1:0] out_q;
  logic [WORD_W-1:0] out_d;
  logic              out_en;

  always_comb begin
    out_en   = clr | load;
    out_d    = clr ? '0 : word_in;
    code_out = {out_q[WORD_W-1] ^ unipolar, out_q[WORD_W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr) |=> $stable(out_q));
  p_prewrite_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> out_q == $past(word_in));
  p_clear_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> out_q == '0);
  p_msb_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unipolar |-> (code_out[WORD_W-1] != out_q[WORD_W-1]));
endmodule

// File: rtl/dac_input_frontend.sv
module dac_input_frontend
  import dacfe_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                wr_n,
  input  logic                lo_sel_n,
  input  logic                hi_sel_n,
  input  logic                xfer_n,
  input  logic                clr_n,
  input  logic [BYTE_W-1:0]   data_in,
  input  logic                unipolar,
  output logic [2*BYTE_W-1:0] code_out
);
  localparam int WORD_W = 2 * BYTE_W;

  logic              rst_sn;
  logic              clr_req;
  logic              clr_s;
  logic              fire;
  in_op_e            op;
  logic              xfer;
  logic [BYTE_W-1:0] cap_data;
  logic [WORD_W-1:0] word;
  logic              load;

  dacfe_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sn)
  );

  assign clr_req = ~clr_n & ~cs_n;

  dacfe_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_clr_sync (
    .clk(clk), .rst_n(rst_sn), .d(clr_req), .q(clr_s)
  );

  dacfe_strobe #(.BYTE_W(BYTE_W), .STAGES(STAGES)) u_strobe (
    .clk(clk), .rst_n(rst_sn), .wr_n(wr_n), .cs_n(cs_n),
    .lo_sel_n(lo_sel_n), .hi_sel_n(hi_sel_n), .xfer_n(xfer_n),
    .data_in(data_in), .fire(fire), .op(op), .xfer(xfer), .data(cap_data)
  );

  dacfe_input_pair #(.BYTE_W(BYTE_W)) u_inputs (
    .clk(clk), .rst_n(rst_sn), .clr(clr_s), .fire(fire), .op(op),
    .data(cap_data), .word(word)
  );

  assign load = fire & xfer;

  dacfe_out_reg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_sn), .clr(clr_s), .load(load),
    .unipolar(unipolar), .word_in(word), .code_out(code_out)
  );
endmodule

// File: tb/sim_dac_input_frontend.sv
module sim_dac_input_frontend;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, wr_n, lo_sel_n, hi_sel_n, xfer_n, clr_n, unipolar;
  logic [7:0]  data_in;
  logic [15:0] code_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dac_input_frontend u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .lo_sel_n(lo_sel_n),
    .hi_sel_n(hi_sel_n), .xfer_n(xfer_n), .clr_n(clr_n), .data_in(data_in),
    .unipolar(unipolar), .code_out(code_out)
  );

  // {cs_n, lo_sel_n, hi_sel_n, xfer_n}, data, expected code after the write
  localparam logic [27:0] VEC [8] = '{
    {4'b0011, 8'h34, 16'h0000},   // R3 low byte, no transfer
    {4'b0101, 8'h12, 16'h0000},   // R4 high byte, no transfer
    {4'b0110, 8'h00, 16'h1234},   // R5 transfer
    {4'b1100, 8'hFF, 16'h1234},   // R2 deselected high+transfer
    {4'b0010, 8'hCD, 16'h1234},   // R7 low + transfer: old word
    {4'b0110, 8'h00, 16'h12CD},   // R3 R2 high byte kept
    {4'b0100, 8'hAB, 16'h12CD},   // R7 high + transfer: old word
    {4'b0110, 8'h00, 16'hABCD}    // R4 transfer
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: code_out=%h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [3:0] f, input logic [7:0] d,
                       input bit mid_chk, input logic [15:0] mid_exp);
    @(posedge clk); #1;
    {cs_n, lo_sel_n, hi_sel_n, xfer_n} = f;
    data_in = d;
    wr_n = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    if (mid_chk) check("R10", code_out, mid_exp);
    wr_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    {cs_n, lo_sel_n, hi_sel_n, xfer_n} = 4'b1111;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; lo_sel_n = 1'b1; hi_sel_n = 1'b1;
    xfer_n = 1'b1; clr_n = 1'b1; unipolar = 1'b0; data_in = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R1", code_out, 16'h0000);

    for (int i = 0; i < 8; i++) begin
      pulse(VEC[i][27:24], VEC[i][23:16], 1'b0, 16'h0000);
      check($sformatf("R2/R3/R4/R5/R7 row %0d", i), code_out, VEC[i][15:0]);
    end

    // R10: nothing moves while the strobe is held low
    pulse(4'b0101, 8'h77, 1'b0, 16'h0000);
    pulse(4'b0110, 8'h00, 1'b1, 16'hABCD);
    check("R10 after release", code_out, 16'h77CD);

    // R6: serial frame A5C3, MSB first, upper data bits hold noise
    for (int b = 15; b >= 0; b--) begin
      logic bitv;
      bitv = (16'hA5C3 >> b) & 1'b1;
      pulse(4'b0001, {~{7{bitv}}, bitv}, 1'b0, 16'h0000);
    end
    check("R6 serial before transfer", code_out, 16'h77CD);
    pulse(4'b0110, 8'h00, 1'b0, 16'h0000);
    check("R6 serial frame", code_out, 16'hA5C3);

    @(posedge clk); #1 unipolar = 1'b1;
    @(posedge clk); #1 check("R9 msb flipped", code_out, 16'h25C3);

    // R2: clear while deselected has no effect
    @(posedge clk); #1 clr_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 clr_n = 1'b1;
    check("R2 deselected clear", code_out, 16'h25C3);

    // R8: clear with chip select
    cs_n = 1'b0; clr_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 clr_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R9 cleared unipolar", code_out, 16'h8000);
    unipolar = 1'b0;
    @(posedge clk); #1 check("R8 cleared bipolar", code_out, 16'h0000);
    pulse(4'b0110, 8'h00, 1'b0, 16'h0000);
    check("R8 input word cleared", code_out, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule